// File: doc/BRIEF.md
# Region Cache Maintenance Engine

This block lets software clean or discard every cache line that overlaps a physical address range without looping over the lines itself. Software writes a control word that selects the operation, then the exclusive end address, then the start address. The write of the start address launches a walk. The walk issues one maintenance request per line, in ascending order, on a valid/ready line port that faces the cache array.

A busy bit in the control word stays set until the last line request has been accepted. The address width is a parameter. When it is wider than 32 bits, separate upper-half registers hold the high bits of each address, and software writes each upper half before its lower half. The line size is also a parameter, either 64 or 128 bytes. Address bits below the line size are discarded, so software does not need to align its values.

A start write that arrives while a walk is running is dropped and sets a sticky error bit. The walk in progress carries on as before.

Top module: `rgn_maint_engine`

## Requirements
- R1: After reset, the control readback is all zeros (busy, error, mode bit and operation field) and `line_valid` is 0.
- R2: The operation field sits at control bits 11..9 and reads back there. Value 000 issues lines with op code 00 (flush). Value 001 with control bit 6 clear issues op code 01 (discard invalidate). Every other field value issues flush regardless of bit 6.
- R3: Operation 001 with control bit 6 set issues op code 10 (flush then invalidate).
- R4: Register select codes are 0 control, 1 end low, 2 end high, 3 start low, 4 start high. Only a write to select 3 launches a walk. Writes to the other selects issue no line requests.
- R5: A walk issues exactly one request per line, in ascending order. It starts at the line that contains the start address and ends at the line that contains end minus 1. Each address has its bits below the line size at zero, and address bits below the line size in start and end have no effect.
- R6: The busy bit (control bit 8) reads 1 in the first cycle after a launching start write. It falls to 0 once the last line request has been accepted.
- R7: When the end address rounded up to a line is at or below the start address rounded down to a line, no request is issued and busy stays 0.
- R8: A start write while busy is set does not change the walk in progress. It sets the sticky error bit (control bit 7). A control write with bit 7 set clears the error bit.
- R9: With a 40-bit address, the low 8 bits written to selects 2 and 4 form address bits 39..32 of end and start. A range that crosses a 4 GiB boundary is walked without a break.
- R10: While `line_valid` is 1 and `line_ready` is 0, `line_addr` and `line_op` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control word readback: op 11..9, busy 8, error 7, mode 6 |
| line_valid | output | 1 | A line request is offered |
| line_ready | input | 1 | The cache accepts the offered request |
| line_addr | output | ADDR_W | Line-aligned address of the request |
| line_op | output | 2 | 00 flush, 01 invalidate, 10 flush then invalidate |

## Verification
The assertions check every cycle that:
- a stalled request holds its address and op code;
- consecutive accepted requests advance by exactly one line;
- the walk position never passes the exclusive limit;
- a launch only happens while idle;
- busy follows a launch according to whether the range is empty.

Only the bench scenarios can show the rest. These are:
- the first and last line of an unaligned range;
- the total line count;
- the op code chosen for each control encoding;
- ranges that cross the 32-bit boundary through the high registers;
- that a start write during a walk leaves the issued sequence unchanged.

// File: rtl/rgn_maint_pkg.sv
// Package: shared encodings of the region cache maintenance engine.
// Assumes control-word bit positions are fixed by software convention.
package rgn_maint_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL     = 3'd0,
        SEL_END_LO   = 3'd1,
        SEL_END_HI   = 3'd2,
        SEL_START_LO = 3'd3,
        SEL_START_HI = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        LOP_FLUSH       = 2'd0,
        LOP_INVAL       = 2'd1,
        LOP_FLUSH_INVAL = 2'd2
    } line_op_e;

    localparam int CTRL_MODE_BIT = 6;
    localparam int CTRL_ERR_BIT  = 7;
    localparam int CTRL_BUSY_BIT = 8;
    localparam int CTRL_OP_LSB   = 9;

    // Map the control operation field and mode bit to a line op code.
    function automatic line_op_e decode_op(input logic [2:0] op, input logic mode);
        if (op == 3'b001) return mode ? LOP_FLUSH_INVAL : LOP_INVAL;
        return LOP_FLUSH;
    endfunction

endpackage

// File: rtl/rgn_maint_regs.sv
// Module: rgn_maint_regs
// Holds the control, end and start registers. It raises a one-cycle launch
// when the start-low register is written while idle, and sets a sticky
// error when that write arrives while busy.
// Assumes ADDR_W >= 32. The upper registers exist only when ADDR_W > 32.
module rgn_maint_regs
    import rgn_maint_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              busy,
    output logic [2:0]        op_sel,
    output logic              mode,
    output logic              err,
    output logic [ADDR_W-1:0] end_addr,
    output logic [ADDR_W-1:0] start_addr,
    output logic              launch
);
    localparam int HI_W = ADDR_W - 32;

    logic [31:0] end_lo_q;
    logic        start_wr;
    logic        reject;

    assign start_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_START_LO);
    assign launch   = start_wr && !busy;
    assign reject   = start_wr && busy;

    // Control fields and the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_sel <= '0;
            mode   <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (wr_en && reg_sel_e'(wr_sel) == SEL_CTRL) begin
                op_sel <= wr_data[CTRL_OP_LSB +: 3];
                mode   <= wr_data[CTRL_MODE_BIT];
            end
            if (reject)
                err <= 1'b1;
            else if (wr_en && reg_sel_e'(wr_sel) == SEL_CTRL && wr_data[CTRL_ERR_BIT])
                err <= 1'b0;
        end
    end

    // Low half of the exclusive end address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            end_lo_q <= '0;
        else if (wr_en && reg_sel_e'(wr_sel) == SEL_END_LO)
            end_lo_q <= wr_data;
    end

    generate
        if (HI_W > 0) begin : g_hi
            logic [HI_W-1:0] end_hi_q;
            logic [HI_W-1:0] start_hi_q;

            // Upper halves, written ahead of their low counterparts.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    end_hi_q   <= '0;
                    start_hi_q <= '0;
                end else if (wr_en) begin
                    if (reg_sel_e'(wr_sel) == SEL_END_HI)   end_hi_q   <= wr_data[HI_W-1:0];
                    if (reg_sel_e'(wr_sel) == SEL_START_HI) start_hi_q <= wr_data[HI_W-1:0];
                end
            end
            assign end_addr   = {end_hi_q, end_lo_q};
            assign start_addr = {start_hi_q, wr_data};
        end else begin : g_lo
            assign end_addr   = end_lo_q;
            assign start_addr = wr_data;
        end
    endgenerate

    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel_e'(wr_sel) == SEL_START_LO && busy) |=> err); // R8

endmodule

// File: rtl/rgn_maint_walker.sv
// Module: rgn_maint_walker
// Converts a launched range into line indices and issues one request per line
// on a valid/ready port. Busy stays high until the last line is accepted.
// Assumes launch is only raised while idle.
module rgn_maint_walker
    import rgn_maint_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [2:0]        op_sel,
    input  logic              mode,
    input  logic              line_ready,
    output logic              busy,
    output logic              line_valid,
    output logic [ADDR_W-1:0] line_addr,
    output logic [1:0]        line_op
);
    localparam int LSB   = $clog2(LINE_BYTES);
    localparam int IDX_W = ADDR_W - LSB;

    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W:0]   lim_idx;
    logic [IDX_W-1:0] first_idx;
    logic [IDX_W:0]   ceil_idx;
    logic [ADDR_W:0]  end_round;
    logic             nonempty;
    logic             accept;
    line_op_e         op_q;

    // Round start down and end up to whole lines.
    always_comb begin
        first_idx = start_addr[ADDR_W-1:LSB];
        end_round = {1'b0, end_addr} + (ADDR_W+1)'(LINE_BYTES - 1);
        ceil_idx  = end_round[ADDR_W:LSB];
        nonempty  = ceil_idx > {1'b0, first_idx};
    end

    assign accept = busy && line_ready;

    // Walk state: the current line, the exclusive limit and the latched op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cur_idx <= '0;
            lim_idx <= '0;
            op_q    <= LOP_FLUSH;
        end else if (launch) begin
            busy    <= nonempty;
            cur_idx <= first_idx;
            lim_idx <= ceil_idx;
            op_q    <= decode_op(op_sel, mode);
        end else if (accept) begin
            if ({1'b0, cur_idx} + 1'b1 == lim_idx)
                busy <= 1'b0;
            else
                cur_idx <= cur_idx + 1'b1;
        end
    end

    assign line_valid = busy;
    assign line_addr  = {cur_idx, {LSB{1'b0}}};
    assign line_op    = op_q;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_ready) |=> ($stable(line_addr) && $stable(line_op))); // R10
    AST_ONE_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && line_ready) |=>
        (!line_valid || line_addr == $past(line_addr) + ADDR_W'(LINE_BYTES))); // R5
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, cur_idx} < lim_idx)); // R5
    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy); // R8
    AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !nonempty) |=> !busy); // R7
    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && nonempty) |=> busy); // R6

endmodule

// File: rtl/rgn_maint_engine.sv
// Module: rgn_maint_engine (top)
// Region cache maintenance engine: a register front end plus a line walker.
// Assumes LINE_BYTES is 64 or 128 and ADDR_W is at least 32.
module rgn_maint_engine
    import rgn_maint_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    output logic [31:0]       ctrl_rdata,
    output logic              line_valid,
    input  logic              line_ready,
    output logic [ADDR_W-1:0] line_addr,
    output logic [1:0]        line_op
);
    logic [2:0]        op_sel;
    logic              mode;
    logic              err;
    logic              busy;
    logic              launch;
    logic [ADDR_W-1:0] end_addr;
    logic [ADDR_W-1:0] start_addr;

    rgn_maint_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .busy       (busy),
        .op_sel     (op_sel),
        .mode       (mode),
        .err        (err),
        .end_addr   (end_addr),
        .start_addr (start_addr),
        .launch     (launch)
    );

    rgn_maint_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .op_sel     (op_sel),
        .mode       (mode),
        .line_ready (line_ready),
        .busy       (busy),
        .line_valid (line_valid),
        .line_addr  (line_addr),
        .line_op    (line_op)
    );

    // Assemble the control readback word.
    always_comb begin
        ctrl_rdata = '0;
        ctrl_rdata[CTRL_OP_LSB +: 3] = op_sel;
        ctrl_rdata[CTRL_BUSY_BIT]    = busy;
        ctrl_rdata[CTRL_ERR_BIT]     = err;
        ctrl_rdata[CTRL_MODE_BIT]    = mode;
    end

endmodule

// File: tb/sim_rgn_maint_engine.sv
module sim_rgn_maint_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_rdata;
    logic        line_valid;
    logic        line_ready = 1'b0;
    logic [39:0] line_addr;
    logic [1:0]  line_op;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rgn_maint_engine #(.ADDR_W(40), .LINE_BYTES(64)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_rdata(ctrl_rdata), .line_valid(line_valid), .line_ready(line_ready),
        .line_addr(line_addr), .line_op(line_op)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    function automatic logic [1:0] exp_op(input logic [2:0] op, input logic m);
        if (op == 3'b001) return m ? 2'd2 : 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [63:0] line_count(input logic [39:0] s, input logic [39:0] e);
        logic [63:0] si, ei;
        si = 64'(s) >> 6;
        ei = (64'(e) + 64'd63) >> 6;
        return (ei > si) ? ei - si : 64'd0;
    endfunction

    // Accept requests with random backpressure and compare against the expected walk (R5).
    task automatic collect(input logic [63:0] first_idx, input logic [63:0] n,
                           input logic [1:0] eop, input string opreq);
        logic [63:0] k = 0;
        int guard = 0;
        forever begin
            @(negedge clk);
            line_ready = ($urandom % 4) != 0;
            #1;
            if (!ctrl_rdata[8]) break;
            if (line_valid && line_ready) begin
                chk(64'(line_addr) == ((first_idx + k) << 6), "R5 line address",
                    64'(line_addr), (first_idx + k) << 6);
                chk(line_op == eop, opreq, 64'(line_op), 64'(eop));
                k++;
            end
            guard++;
            if (guard > 20000) break;
        end
        line_ready = 1'b0;
        chk(k == n, "R5 line count", k, n);
    endtask

    task automatic do_range(input logic [39:0] s, input logic [39:0] e,
                            input logic [2:0] op, input logic m);
        logic [63:0] n;
        logic [1:0]  eo;
        n  = line_count(s, e);
        eo = exp_op(op, m);
        wr(3'd0, (32'(op) << 9) | (32'(m) << 6));
        chk(ctrl_rdata[11:9] == op && ctrl_rdata[6] == m, "R2 field readback",
            64'(ctrl_rdata), 64'((32'(op) << 9) | (32'(m) << 6)));
        wr(3'd2, 32'(e[39:32]));
        wr(3'd1, e[31:0]);
        wr(3'd4, 32'(s[39:32]));
        wr(3'd3, s[31:0]);
        if (n > 0) chk(ctrl_rdata[8] == 1'b1, "R6 busy on first read", 64'(ctrl_rdata[8]), 64'd1);
        else       chk(ctrl_rdata[8] == 1'b0 && !line_valid, "R7 empty range idle",
                       64'(ctrl_rdata[8]), 64'd0);
        collect(64'(s) >> 6, n, eo, (eo == 2'd2) ? "R3 op code" : "R2 op code");
        chk(ctrl_rdata[8] == 1'b0, "R6 busy clears", 64'(ctrl_rdata[8]), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog R6 actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [39:0] s, e;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ctrl_rdata == 32'd0 && !line_valid, "R1 reset state", 64'(ctrl_rdata), 64'd0);

        // R4: non-start writes launch nothing
        wr(3'd0, 32'h0000_0200);
        wr(3'd2, 32'h0);
        wr(3'd1, 32'h0000_2000);
        wr(3'd4, 32'h0);
        repeat (3) @(negedge clk);
        chk(!line_valid && ctrl_rdata[8] == 1'b0, "R4 no launch without start", 64'(line_valid), 64'd0);

        // Directed corners
        do_range(40'h00_0000_1000, 40'h00_0000_1040, 3'b000, 1'b0);   // R5 exact single line
        do_range(40'h00_0000_1003, 40'h00_0000_1041, 3'b001, 1'b0);   // R5 unaligned, two lines
        do_range(40'h00_0000_1000, 40'h00_0000_1000, 3'b001, 1'b1);   // R7 end == start
        do_range(40'h00_0000_2000, 40'h00_0000_1000, 3'b000, 1'b0);   // R7 end below start
        do_range(40'h00_0000_2030, 40'h00_0000_2001, 3'b000, 1'b0);   // R7/R5 same line
        do_range(40'h10_FFFF_FFC0, 40'h11_0000_0040, 3'b001, 1'b1);   // R9 crosses 4 GiB, R3
        do_range(40'h00_0000_3000, 40'h00_0000_3100, 3'b101, 1'b1);   // R2 reserved -> flush

        // R8: start write during a walk is dropped and flagged
        wr(3'd0, 32'h0000_0200);
        wr(3'd2, 32'h0);
        wr(3'd1, 32'h0000_4200);
        wr(3'd4, 32'h0);
        wr(3'd3, 32'h0000_4000);
        wr(3'd3, 32'h0000_9000);
        chk(ctrl_rdata[7] == 1'b1, "R8 error set", 64'(ctrl_rdata[7]), 64'd1);
        collect(64'h100, 64'd8, 2'd1, "R2 op code");
        wr(3'd0, 32'h0000_0280);
        chk(ctrl_rdata[7] == 1'b0 && ctrl_rdata[11:9] == 3'b001, "R8 error cleared",
            64'(ctrl_rdata), 64'h200);

        // Constrained random ranges
        for (int i = 0; i < 25; i++) begin
            s = {8'($urandom % 200), 32'($urandom)};
            e = s + 40'($urandom % 700);
            do_range(s, e, 3'($urandom % 8), 1'($urandom % 2));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule